// File: doc/BRIEF.md
# Interrupt Status and Mask Register Block

This block gathers thirty-two asynchronous interrupt lines for a processor core. Each line passes through a synchroniser and is then recorded in a status register. Each line also has an enable bit in a mask register, and a single request goes to the core whenever an enabled line is pending. Software reaches both registers through a small special-register port. The port has a one-bit register select, a write strobe, a write data word and a read data word. Read data is combinational.

A build-time parameter fixes how status bits are set and cleared. There are three behaviours:
- Level: status simply mirrors the synchronised inputs, and status writes are ignored.
- Edge: a rising edge latches the bit, and software clears it by writing one.
- Latched level: a high input latches the bit, and software clears it by writing zero, so a status write ANDs the data into the register.

The block also reports the lowest-numbered pending status bit with a valid flag, so that the dispatcher can start from the lowest line and work upward. The register logic has no sequencing states. Every register is updated directly from the current inputs on each clock.

Top module: `pic_regs`

## Requirements
- R1: While reset is asserted and right after it, the mask reads all zeros, `irq_req` is 0 and `pend_valid` is 0.
- R2: A write with `reg_sel`=0 loads the mask register from `reg_wdata`; bit n set enables line n. `irq_req` is 1 exactly when some bit is set in both status and mask.
- R3: Each input passes two synchroniser flops before it reaches the status logic. A change on `irq_in` first shows in the status register three clock edges later.
- R4: In edge mode (`MODE`=CLR_EDGE, value 1), a 0-to-1 transition of a synchronised input sets its status bit. The bit stays set after the input falls.
- R5: In edge mode, a status write (`reg_sel`=1) clears every status bit whose `reg_wdata` bit is 1. Bits written with 0 are unchanged.
- R6: In level mode (`MODE`=CLR_LEVEL, value 0), status equals the synchronised inputs delayed by one register, and status writes have no effect.
- R7: In latched-level mode (`MODE`=CLR_LATCH, value 2), a high synchronised input sets its status bit. A status write makes the status equal to the old status AND `reg_wdata`.
- R8: In edge and latched-level modes, a hardware set in the same cycle as a software clear of that bit leaves the bit set.
- R9: `pend_idx` gives the index of the lowest set status bit and `pend_valid` is 1. When status is all zeros, `pend_valid` is 0. The mask does not affect either output.
- R10: `reg_rdata` returns the mask when `reg_sel`=0 and the status when `reg_sel`=1, combinationally within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_LINES | Asynchronous interrupt lines |
| reg_sel | input | 1 | Register select: 0 mask, 1 status |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | N_LINES | Write data |
| reg_rdata | output | N_LINES | Read data of the selected register |
| irq_req | output | 1 | Request to the core |
| pend_idx | output | $clog2(N_LINES) | Lowest pending line index |
| pend_valid | output | 1 | Some status bit is set |

## Verification
The hardest case to reach from the ports is a hardware set arriving in exactly the cycle of a software clear of the same bit. In edge mode the bench must time the clear to the single cycle in which the synchronised edge is seen. To do this, the bench raises the line and counts two clock edges through the synchroniser. It then places the clearing write on the third edge. Long random runs with sparse inputs and frequent register writes, checked against a cycle model in the bench, cover the remaining interactions in all three modes at once.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;

    typedef enum logic [1:0] {
        CLR_LEVEL = 2'd0,
        CLR_EDGE  = 2'd1,
        CLR_LATCH = 2'd2
    } clr_mode_e;

    typedef enum logic {
        SEL_MASK = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/pic_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser with one extra delayed copy for edge detection.
module pic_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] chain [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= din;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
        end
    end

    assign q      = chain[STAGES-1];
    assign q_prev = chain[STAGES];
endmodule

// File: rtl/pic_status.sv
`timescale 1ns/1ps
// Status register with mode-selected set and clear rules.
module pic_status
    import pic_pkg::*;
#(
    parameter int        W    = 32,
    parameter clr_mode_e MODE = CLR_EDGE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] lvl_prev,
    input  logic         wr_stat,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status
);
    logic [W-1:0] status_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr_ones;
    logic [W-1:0] keep_and;
    logic [W-1:0] nxt_edge;
    logic [W-1:0] nxt_latch;
    logic [W-1:0] nxt;

    always_comb begin
        rise      = lvl & ~lvl_prev;
        clr_ones  = wr_stat ? wdata : '0;
        keep_and  = wr_stat ? (status_q & wdata) : status_q;
        // the hardware set term is ORed last, so it wins over a clear
        nxt_edge  = (status_q & ~clr_ones) | rise;
        nxt_latch = keep_and | lvl;
        unique case (MODE)
            CLR_LEVEL: nxt = lvl;
            CLR_EDGE:  nxt = nxt_edge;
            CLR_LATCH: nxt = nxt_latch;
            default:   nxt = lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= nxt;
    end

    assign status = status_q;
endmodule

// File: rtl/pic_prio.sv
`timescale 1ns/1ps
// Lowest-set-bit finder.
module pic_prio #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             vld
);
    always_comb begin
        idx = '0;
        vld = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = i[IDX_W-1:0];
                vld = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pic_regs.sv
`timescale 1ns/1ps
module pic_regs
    import pic_pkg::*;
#(
    parameter int        N_LINES     = 32,
    parameter int        SYNC_STAGES = 2,
    parameter clr_mode_e MODE        = CLR_EDGE,
    localparam int       IDX_W       = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [N_LINES-1:0] reg_wdata,
    output logic [N_LINES-1:0] reg_rdata,
    output logic               irq_req,
    output logic [IDX_W-1:0]   pend_idx,
    output logic               pend_valid
);
    logic [N_LINES-1:0] lvl_s;
    logic [N_LINES-1:0] lvl_d;
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] status_q;
    logic               wr_mask;
    logic               wr_stat;

    assign wr_mask = reg_we && (reg_sel == SEL_MASK);
    assign wr_stat = reg_we && (reg_sel == SEL_STAT);

    pic_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (irq_in),
        .q      (lvl_s),
        .q_prev (lvl_d)
    );

    pic_status #(.W(N_LINES), .MODE(MODE)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_s),
        .lvl_prev (lvl_d),
        .wr_stat  (wr_stat),
        .wdata    (reg_wdata),
        .status   (status_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= reg_wdata;
    end

    pic_prio #(.W(N_LINES), .IDX_W(IDX_W)) u_prio (
        .vec (status_q),
        .idx (pend_idx),
        .vld (pend_valid)
    );

    assign reg_rdata = (reg_sel == SEL_STAT) ? status_q : mask_q;
    assign irq_req   = |(status_q & mask_q);
endmodule

// File: rtl/pic_regs_chk.sv
`timescale 1ns/1ps
module pic_regs_chk
    import pic_pkg::*;
#(
    parameter int        N_LINES = 32,
    parameter clr_mode_e MODE    = CLR_EDGE,
    localparam int       IDX_W   = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_sel,
    input logic               reg_we,
    input logic [N_LINES-1:0] mask_q,
    input logic [N_LINES-1:0] status_q,
    input logic [N_LINES-1:0] lvl,
    input logic               irq_req,
    input logic [IDX_W-1:0]   pend_idx,
    input logic               pend_valid
);
    localparam logic [N_LINES-1:0] ONE = 1;

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (mask_q != '0)); // R2

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_sel == SEL_MASK) |=> $stable(mask_q)); // R2

    AST_NEW_BIT_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(lvl)) == '0)); // R3

    AST_IDX_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> status_q[pend_idx]); // R9

    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> ((status_q & ((ONE << pend_idx) - ONE)) == '0)); // R9

    AST_NO_PEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |-> (status_q == '0)); // R9

    if (MODE != CLR_LEVEL) begin : g_sticky
        AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_we && reg_sel == SEL_STAT) |=>
                ((status_q & $past(status_q)) == $past(status_q))); // R4
    end

    if (MODE == CLR_LATCH) begin : g_latch
        AST_LATCH_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((status_q & $past(lvl)) == $past(lvl))); // R8
    end
endmodule

bind pic_regs pic_regs_chk #(.N_LINES(N_LINES), .MODE(MODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_we     (reg_we),
    .mask_q     (mask_q),
    .status_q   (status_q),
    .lvl        (lvl_s),
    .irq_req    (irq_req),
    .pend_idx   (pend_idx),
    .pend_valid (pend_valid)
);

// File: tb/sim_pic_regs.sv
`timescale 1ns/1ps
module sim_pic_regs;
    import pic_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;

    logic [31:0] rd  [3];
    logic        irq [3];
    logic [4:0]  idx [3];
    logic        vld [3];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    // index 0: edge, 1: level, 2: latched level
    pic_regs #(.MODE(CLR_EDGE)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(rd[0]), .irq_req(irq[0]), .pend_idx(idx[0]),
        .pend_valid(vld[0]));
    pic_regs #(.MODE(CLR_LEVEL)) u1 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(rd[1]), .irq_req(irq[1]), .pend_idx(idx[1]),
        .pend_valid(vld[1]));
    pic_regs #(.MODE(CLR_LATCH)) u2 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(rd[2]), .irq_req(irq[2]), .pend_idx(idx[2]),
        .pend_valid(vld[2]));

    // cycle model
    logic [31:0] s1, s2, s3, m_mask;
    logic [31:0] m_stat [3];

    always @(posedge clk or negedge rst_n) begin
        logic [31:0] clr, e_n, v_n, l_n;
        if (!rst_n) begin
            s1 = '0; s2 = '0; s3 = '0; m_mask = '0;
            for (int k = 0; k < 3; k++) m_stat[k] = '0;
        end else begin
            clr = (reg_we && reg_sel) ? reg_wdata : '0;
            e_n = (m_stat[0] & ~clr) | (s2 & ~s3);
            v_n = s2;
            l_n = ((reg_we && reg_sel) ? (m_stat[2] & reg_wdata) : m_stat[2]) | s2;
            if (reg_we && !reg_sel) m_mask = reg_wdata;
            m_stat[0] = e_n; m_stat[1] = v_n; m_stat[2] = l_n;
            s3 = s2; s2 = s1; s1 = irq_in;
        end
    end

    function automatic logic [5:0] low_idx(logic [31:0] v);
        logic [5:0] r = 6'd0;
        for (int i = 31; i >= 0; i--) if (v[i]) r = {1'b1, i[4:0]};
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        string st [3] = '{"R4/R5 edge status", "R6 level status", "R7 latch status"};
        for (int k = 0; k < 3; k++) begin
            logic [5:0] li = low_idx(m_stat[k]);
            if (reg_sel) chk(st[k], rd[k], m_stat[k]);
            else         chk("R2 mask", rd[k], m_mask);
            chk("R2 irq_req", {31'd0, irq[k]}, {31'd0, |(m_stat[k] & m_mask)});
            chk("R9 valid", {31'd0, vld[k]}, {31'd0, li[5]});
            if (li[5]) chk("R9 index", {27'd0, idx[k]}, {27'd0, li[4:0]});
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(logic sel, logic [31:0] d);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 during reset
        for (int k = 0; k < 3; k++) begin
            chk("R1 mask in reset", rd[k], 32'd0);
            chk("R1 irq in reset", {31'd0, irq[k]}, 32'd0);
            chk("R1 valid in reset", {31'd0, vld[k]}, 32'd0);
        end
        rst_n = 1'b1;
        step();
        chk("R1 mask after reset", rd[0], 32'd0);

        // R3: synchroniser latency
        reg_sel = 1'b1;
        irq_in = 32'h0000_0020;
        step(); chk("R3 not yet after 1 edge", rd[1], 32'd0);
        step(); chk("R3 not yet after 2 edges", rd[1], 32'd0);
        step(); chk("R3 seen after 3 edges", rd[1], 32'h20);

        wr(1'b0, 32'hFFFF_FFFF);
        chk("R2 mask readback", rd[0], 32'hFFFF_FFFF);

        // R4: edge latch persists
        irq_in = '0;
        repeat (4) step();
        reg_sel = 1'b1; #1;
        chk("R4 edge bit held", rd[0], 32'h20);
        chk("R6 level follows", rd[1], 32'h0);
        chk("R7 latch bit held", rd[2], 32'h20);

        // R5/R7: write zero clears latch only, write one clears edge only
        wr(1'b1, 32'h0);
        chk("R5 zero write keeps edge", rd[0], 32'h20);
        chk("R7 zero write clears latch", rd[2], 32'h0);
        wr(1'b1, 32'h20);
        chk("R5 one write clears edge", rd[0], 32'h0);

        // R6 / R8 latched: hold bit 9 high, write zeros
        irq_in = 32'h200;
        repeat (4) step();
        wr(1'b1, 32'h0);
        chk("R6 level ignores write", rd[1], 32'h200);
        chk("R8 latch set beats clear", rd[2], 32'h200);

        // R8 edge: rise coincides with a write-one clear
        irq_in = '0;
        repeat (4) step();
        chk("R8 edge pre", rd[0], 32'h200);
        irq_in = 32'h200;
        step(); step();
        wr(1'b1, 32'h200);
        chk("R8 edge set beats clear", rd[0], 32'h200);

        // R9: all clear, then two pending
        irq_in = '0;
        repeat (4) step();
        wr(1'b1, 32'hFFFF_FFFF);
        wr(1'b1, 32'h0);
        step();
        for (int k = 0; k < 3; k++) chk("R9 none pending", {31'd0, vld[k]}, 32'd0);
        irq_in = 32'h8002_0000;
        repeat (4) step();
        chk("R9 lowest index", {27'd0, idx[0]}, 32'd17);

        // R2: mask zero blocks request; R10 combinational select
        wr(1'b0, 32'h0);
        chk("R2 masked no irq", {31'd0, irq[2]}, 32'd0);
        reg_sel = 1'b1; #1;
        chk("R10 status select", rd[2], 32'h8002_0000);
        reg_sel = 1'b0; #1;
        chk("R10 mask select", rd[2], 32'h0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            irq_in    = $urandom & $urandom & $urandom;
            reg_we    = ($urandom % 4) == 0;
            reg_sel   = $urandom % 2;
            reg_wdata = $urandom;
            step();
        end
        reg_we = 1'b0;
        summary();
    end
endmodule